// File: doc/BRIEF.md
# Latched-Address 3-to-8 Decoder

The block turns a 3-bit select value into a one-of-eight output pattern with active-low outputs. The chosen output is driven low and the other seven stay high. In front of the decode sits an address hold stage. While the hold input is low, the decoder follows the select inputs directly. When the hold input rises, the select value seen at that clock edge is kept. The decoder keeps using that value while hold stays high, whatever happens on the select inputs.

Two output enables, one active high and one active low, force every output high when either one is inactive. They do not depend on the select or hold inputs, and they do not change the kept address. The design is synchronous and uses one clock. A register on the hold input finds its rising edge, and a bypass mux gives the same cycle response that a transparent latch would give. The decode outputs are combinational from the inputs and the kept state.

Top module: `latched_decoder`

## Requirements
- R1: The select bus is binary weighted, with bit 0 weight 1, bit 1 weight 2 and bit 2 weight 4. Value k picks output index k.
- R2: The outputs are active low. When enabled, exactly one output bit is 0, the bit at the picked index. All other output bits are 1.
- R3: While `hold` is low, the outputs follow the current `sel` within the same cycle.
- R4: In the cycle where `hold` goes from low to high, the current `sel` is decoded. That value is kept at the clock edge.
- R5: While `hold` stays high after its rising cycle, changes on `sel` have no effect. The outputs show the kept address.
- R6: All outputs are 1 whenever `oe` is 0 or `oe_n` is 1, for any `sel` and `hold`.
- R7: Disabling the outputs and enabling them again while `hold` stays high does not change the kept address.
- R8: A synchronous active-high reset clears the kept address to 0 and the hold history to low. A `hold` that is already high when reset is released counts as a new rising edge, so the current `sel` is kept and decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 3 | Select address |
| hold | input | 1 | Low: transparent decode. Rising: keep the address. High: decode the kept address |
| oe | input | 1 | Output enable, active high |
| oe_n | input | 1 | Output enable, active low |
| y_n | output | 8 | Decoded outputs, active low |

## Verification
Four things are checked by properties on every cycle: at most one output is low, disabled outputs are all high, transparent decoding follows `sel`, and the kept address loads only on a hold rising edge and stays stable while hold is high. The bench shows the rest through scenarios. It runs every address under every enable combination. For each address it captures the value and sweeps `sel` while holding. It toggles the enables while holding, then checks that the original index comes back. It also checks the reset case where hold is high when reset is released.

// File: rtl/latched_decoder.sv
module latched_decoder #(
  parameter int SEL_W = 3,
  localparam int N = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             hold,
  input  logic             oe,
  input  logic             oe_n,
  output logic [N-1:0]     y_n
);

  logic [SEL_W-1:0] addr_q;
  logic             hold_q;
  logic             capture;
  logic [SEL_W-1:0] addr_eff;
  logic             enabled;

  assign capture  = hold & ~hold_q;
  assign addr_eff = (!hold || capture) ? sel : addr_q;
  assign enabled  = oe & ~oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= hold;
      if (capture) addr_q <= sel;
    end
  end

  always_comb begin
    y_n = '1;
    if (enabled) y_n[addr_eff] = 1'b0;
  end

  a_r2_single_low: assert property (@(posedge clk) disable iff (rst)
    $countones(~y_n) <= 1);

  a_r6_disabled_high: assert property (@(posedge clk) disable iff (rst)
    (!oe || oe_n) |-> (y_n == {N{1'b1}}));

  a_r3_transparent: assert property (@(posedge clk) disable iff (rst)
    (oe && !oe_n && !hold) |-> (y_n[sel] == 1'b0));

  a_r4_capture: assert property (@(posedge clk) disable iff (rst)
    (hold && !hold_q) |=> (addr_q == $past(sel)));

  a_r5_r7_held_stable: assert property (@(posedge clk) disable iff (rst)
    (hold && hold_q) |=> $stable(addr_q));

endmodule

// File: tb/test_latched_decoder.sv
module test_latched_decoder;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] sel;
  logic       hold, oe, oe_n;
  logic [7:0] y_n;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [2:0] m_addr;
  logic       m_prev;

  always #5 clk = ~clk;

  latched_decoder i_latched_decoder (
    .clk(clk), .rst(rst), .sel(sel), .hold(hold),
    .oe(oe), .oe_n(oe_n), .y_n(y_n)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_addr <= 3'd0;
      m_prev <= 1'b0;
    end else begin
      if (hold && !m_prev) m_addr <= sel;
      m_prev <= hold;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] expect_y();
    logic [2:0] a;
    a = (!hold || !m_prev) ? sel : m_addr;
    if (!oe || oe_n) return 8'hFF;
    return ~(8'd1 << a);
  endfunction

  task automatic step(input logic [2:0] s, input logic h, input logic e, input logic en, input string tag);
    @(negedge clk);
    sel = s; hold = h; oe = e; oe_n = en;
    #1;
    checks++;
    if (y_n !== expect_y()) begin
      fails++;
      $display("FAIL %s: sel=%0d hold=%b oe=%b oe_n=%b actual=%b expected=%b",
               tag, s, h, e, en, y_n, expect_y());
    end
  endtask

  initial begin
    rst = 1'b1; sel = 3'd0; hold = 1'b0; oe = 1'b1; oe_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    step(3'd0, 1'b0, 1'b1, 1'b0, "R8 reset transparent");

    for (int k = 0; k < 8; k++)
      for (int e = 0; e < 4; e++)
        step(3'(k), 1'b0, e[0], e[1], "R1 R2 R3 R6 transparent sweep");

    for (int a = 0; a < 8; a++) begin
      step(3'(a), 1'b0, 1'b1, 1'b0, "R3 setup");
      step(3'(a), 1'b1, 1'b1, 1'b0, "R4 capture");
      for (int s = 0; s < 8; s++)
        step(3'(s), 1'b1, 1'b1, 1'b0, "R5 hold ignores sel");
      for (int e = 0; e < 4; e++)
        step(3'(7 - a), 1'b1, e[0], e[1], "R6 R7 enables while held");
      step(3'(a ^ 3'd5), 1'b1, 1'b1, 1'b0, "R7 address kept after re-enable");
      step(3'(a ^ 3'd3), 1'b0, 1'b1, 1'b0, "R3 release to transparent");
    end

    step(3'd5, 1'b0, 1'b1, 1'b0, "R3 pre");
    step(3'd5, 1'b1, 1'b1, 1'b0, "R4 capture 5");
    @(negedge clk); rst = 1'b1; sel = 3'd2;
    @(negedge clk); rst = 1'b0;
    step(3'd2, 1'b1, 1'b1, 1'b0, "R8 hold high at reset release");
    step(3'd6, 1'b1, 1'b1, 1'b0, "R8 kept after reset capture");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule